// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block runs the transfer loop of a single DMA channel. When a run is requested it takes the channel's source address, destination address, 24-bit transfer count, control word and a unit limit. It then moves data one unit at a time. Each unit is one memory read followed by one memory write, and each access uses a valid/ready handshake. After every completed unit the source and destination addresses step according to their own modes, and the count drops by one.

At the end of a run the block presents the updated addresses, the remaining count and the updated control word for one cycle, so that the channel registers can be written back and a later run can resume where this one stopped. The control word also selects the unit size. If either address mode is illegal, the block moves no data and reports the error. When the count reaches zero, the block sets the transfer-end flag, and it raises a completion interrupt if interrupts are enabled.

Top module: `dmaseq_top`

## Requirements
- R1: The unit size comes from control bits [6:4], using the table 0→8, 1→1, 2→2, 3→4, 4→32, 5→1, 6→1, 7→1 bytes. It is driven on `unit_bytes_o`, and `wr_data_o` carries the read data in its low bytes.
- R2: Control bits [13:12] set the source mode. Mode 0 keeps the read address fixed, mode 1 adds the unit size after each unit, and mode 2 subtracts it. Addresses wrap modulo 2^32.
- R3: Control bits [15:14] set the destination mode, with the same encoding as the source mode, and it is applied to the write address.
- R4: If either mode field equals 3, a run issues no read and no write. `illegal_o` pulses together with `wb_valid_o`, and the written-back addresses, count and control word equal the loaded ones.
- R5: A loaded count of 0 means 2^24 units. A limited run on such a count writes back 2^24 minus the number of units moved, taken modulo 2^24.
- R6: The count drops by one for each completed write. When `wb_valid_o` is high for one cycle, `src_addr_o`, `dst_addr_o` and `count_o` hold the state after the last unit.
- R7: When the remaining count reaches 0, `ctrl_o` is the loaded control word with bit 1 (transfer end) set. `irq_o` pulses with `wb_valid_o` only if control bit 2 (interrupt enable) is also set. Otherwise `ctrl_o` equals the loaded word and `irq_o` stays low.
- R8: A run moves `run_units_i` units. If `run_units_i` is 0 or exceeds the remaining count, the run goes on until the count is exhausted.
- R9: Each unit is one read followed by one write. The read address, the write address and the write data stay stable while valid is high and ready is low.
- R10: `start_i` is accepted only while the block is idle. `busy_o` is high from the cycle after acceptance through the write-back cycle. A `start_i` raised during a run has no effect on that run.
- R11: After reset the block is idle, and `busy_o`, `rd_valid_o`, `wr_valid_o`, `wb_valid_o`, `illegal_o` and `irq_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Run request, sampled while idle |
| run_units_i | input | 24 | Units to move; 0 means run to end |
| src_addr_i | input | 32 | Loaded source address |
| dst_addr_i | input | 32 | Loaded destination address |
| count_i | input | 24 | Loaded transfer count; 0 means 2^24 |
| ctrl_i | input | 16 | Loaded control word |
| busy_o | output | 1 | Run in progress |
| rd_valid_o | output | 1 | Read request valid |
| rd_ready_i | input | 1 | Read accepted, data present |
| rd_addr_o | output | 32 | Read address |
| rd_data_i | input | 256 | Read data, unit in low bytes |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Write accepted |
| wr_addr_o | output | 32 | Write address |
| wr_data_o | output | 256 | Write data |
| unit_bytes_o | output | 6 | Unit size in bytes |
| wb_valid_o | output | 1 | Write-back values valid, one cycle |
| src_addr_o | output | 32 | Updated source address |
| dst_addr_o | output | 32 | Updated destination address |
| count_o | output | 24 | Remaining count |
| ctrl_o | output | 16 | Updated control word |
| illegal_o | output | 1 | Run refused because of an illegal mode |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
The bench goes after the non-monotonic size table at codes 0, 4 and 5 to 7. A design that indexed linearly would step by the wrong amount and write the wrong number of bytes. It covers mode 3 on each address field separately; a design that treated mode 3 as fixed would move data that it must refuse. It covers a zero count under a limited run, where a design without the 2^24 rule would write back an underflowed value or end at once. It covers run limits of zero, limits larger than the count, and a partial run that is resumed from the written-back values, which exposes an off-by-one in the count or a lost address update. Every case uses random ready stalls, and it separates the transfer-end and interrupt-enable conditions, which exposes interrupts raised without enable or flags set early.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
  localparam int unsigned UNIT_W    = 6;
  localparam int unsigned SIZE_LSB  = 4;
  localparam int unsigned SRC_LSB   = 12;
  localparam int unsigned DST_LSB   = 14;
  localparam int unsigned TE_BIT    = 1;
  localparam int unsigned IE_BIT    = 2;

  typedef enum logic [1:0] {
    AM_FIXED = 2'd0,
    AM_INC   = 2'd1,
    AM_DEC   = 2'd2,
    AM_BAD   = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_FIN
  } seq_state_e;

  function automatic logic [UNIT_W-1:0] unit_bytes(input logic [2:0] code);
    case (code)
      3'd0:    unit_bytes = 6'd8;
      3'd2:    unit_bytes = 6'd2;
      3'd3:    unit_bytes = 6'd4;
      3'd4:    unit_bytes = 6'd32;
      default: unit_bytes = 6'd1;
    endcase
  endfunction
endpackage

// File: rtl/dmaseq_decode.sv
module dmaseq_decode
  import dmaseq_pkg::*;
(
  input  logic [2:0]        size_code_i,
  input  logic [1:0]        src_mode_i,
  input  logic [1:0]        dst_mode_i,
  output logic [UNIT_W-1:0] size_o,
  output addr_mode_e        src_mode_o,
  output addr_mode_e        dst_mode_o,
  output logic              illegal_o
);
  always_comb begin
    size_o     = unit_bytes(size_code_i);
    src_mode_o = addr_mode_e'(src_mode_i);
    dst_mode_o = addr_mode_e'(dst_mode_i);
    illegal_o  = (src_mode_o == AM_BAD) || (dst_mode_o == AM_BAD);
  end

  always_comb begin
    a_r1_size_range: assert (size_o inside {6'd1, 6'd2, 6'd4, 6'd8, 6'd32});
  end
endmodule

// File: rtl/dmaseq_addr_step.sv
module dmaseq_addr_step
  import dmaseq_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [AW-1:0]     load_addr_i,
  input  addr_mode_e        load_mode_i,
  input  logic              step_i,
  input  logic [UNIT_W-1:0] size_i,
  output logic [AW-1:0]     addr_o
);
  logic [AW-1:0] addr_q;
  addr_mode_e    mode_q;
  logic [AW-1:0] size_ext;

  assign size_ext = AW'(size_i);
  assign addr_o   = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      mode_q <= AM_FIXED;
    end else if (load_i) begin
      addr_q <= load_addr_i;
      mode_q <= load_mode_i;
    end else if (step_i) begin
      case (mode_q)
        AM_INC:  addr_q <= addr_q + size_ext;
        AM_DEC:  addr_q <= addr_q - size_ext;
        default: addr_q <= addr_q;
      endcase
    end
  end

  a_r2_fixed_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && mode_q == AM_FIXED) |=> $stable(addr_q));
  a_r3_no_step_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(addr_q));
  a_r2_inc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && mode_q == AM_INC) |=> addr_q == $past(addr_q) + $past(size_ext));
endmodule

// File: rtl/dmaseq_counter.sv
module dmaseq_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] run_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] remain_o,
  output logic             empty_o,
  output logic             last_o
);
  localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};

  logic [CNT_W:0] remain_q, left_q;
  logic [CNT_W:0] loaded, run_ext, run_pick;

  always_comb begin
    loaded   = (count_i == '0) ? FULL : {1'b0, count_i};
    run_ext  = {1'b0, run_i};
    run_pick = (run_i == '0 || run_ext > loaded) ? loaded : run_ext;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= '0;
      left_q   <= '0;
    end else if (load_i) begin
      remain_q <= loaded;
      left_q   <= run_pick;
    end else if (dec_i) begin
      remain_q <= remain_q - 1'b1;
      left_q   <= left_q - 1'b1;
    end
  end

  assign remain_o = remain_q[CNT_W-1:0];
  assign empty_o  = (remain_q == '0);
  assign last_o   = (left_q == {{CNT_W{1'b0}}, 1'b1});

  a_r6_dec_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |=> remain_q == $past(remain_q) - 1'b1);
  a_r5_zero_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && count_i == '0) |=> remain_q == FULL);
  a_r8_left_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (left_q <= remain_q) && (left_q != '0));
endmodule

// File: rtl/dmaseq_top.sv
module dmaseq_top
  import dmaseq_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned CTRL_W = 16,
  parameter int unsigned DW     = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  run_units_i,
  input  logic [AW-1:0]     src_addr_i,
  input  logic [AW-1:0]     dst_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              busy_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [AW-1:0]     rd_addr_o,
  input  logic [DW-1:0]     rd_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [AW-1:0]     wr_addr_o,
  output logic [DW-1:0]     wr_data_o,
  output logic [UNIT_W-1:0] unit_bytes_o,
  output logic              wb_valid_o,
  output logic [AW-1:0]     src_addr_o,
  output logic [AW-1:0]     dst_addr_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              illegal_o,
  output logic              irq_o
);
  localparam int unsigned NADDR = 2;

  seq_state_e         state_q, state_d;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [UNIT_W-1:0]  size_q, dec_size;
  logic               illegal_q, dec_illegal;
  addr_mode_e         dec_src_mode, dec_dst_mode;
  logic [DW-1:0]      data_q;
  logic               accept, unit_done, cnt_empty, cnt_last;
  logic               te_set;

  logic [AW-1:0]      ld_addr [NADDR];
  addr_mode_e         ld_mode [NADDR];
  logic [AW-1:0]      cur_addr[NADDR];

  dmaseq_decode u_decode (
    .size_code_i (ctrl_i[SIZE_LSB +: 3]),
    .src_mode_i  (ctrl_i[SRC_LSB +: 2]),
    .dst_mode_i  (ctrl_i[DST_LSB +: 2]),
    .size_o      (dec_size),
    .src_mode_o  (dec_src_mode),
    .dst_mode_o  (dec_dst_mode),
    .illegal_o   (dec_illegal)
  );

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign unit_done = (state_q == ST_WR) && wr_ready_i;

  assign ld_addr[0] = src_addr_i;
  assign ld_addr[1] = dst_addr_i;
  assign ld_mode[0] = dec_src_mode;
  assign ld_mode[1] = dec_dst_mode;

  for (genvar g = 0; g < NADDR; g++) begin : g_addr
    dmaseq_addr_step #(.AW(AW)) u_step (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (accept),
      .load_addr_i (ld_addr[g]),
      .load_mode_i (ld_mode[g]),
      .step_i      (unit_done),
      .size_i      (size_q),
      .addr_o      (cur_addr[g])
    );
  end

  dmaseq_counter #(.CNT_W(CNT_W)) u_count (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .count_i  (count_i),
    .run_i    (run_units_i),
    .dec_i    (unit_done),
    .remain_o (count_o),
    .empty_o  (cnt_empty),
    .last_o   (cnt_last)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) state_d = dec_illegal ? ST_FIN : ST_RD;
      ST_RD:   if (rd_ready_i) state_d = ST_WR;
      ST_WR:   if (wr_ready_i) state_d = cnt_last ? ST_FIN : ST_RD;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ctrl_q    <= '0;
      size_q    <= '0;
      illegal_q <= 1'b0;
      data_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        ctrl_q    <= ctrl_i;
        size_q    <= dec_size;
        illegal_q <= dec_illegal;
      end
      if (state_q == ST_RD && rd_ready_i) data_q <= rd_data_i;
    end
  end

  assign te_set = cnt_empty && !illegal_q;

  always_comb begin
    ctrl_o         = ctrl_q;
    ctrl_o[TE_BIT] = ctrl_q[TE_BIT] | te_set;
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign rd_valid_o   = (state_q == ST_RD);
  assign wr_valid_o   = (state_q == ST_WR);
  assign rd_addr_o    = cur_addr[0];
  assign wr_addr_o    = cur_addr[1];
  assign src_addr_o   = cur_addr[0];
  assign dst_addr_o   = cur_addr[1];
  assign wr_data_o    = data_q;
  assign unit_bytes_o = size_q;
  assign wb_valid_o   = (state_q == ST_FIN);
  assign illegal_o    = wb_valid_o && illegal_q;
  assign irq_o        = wb_valid_o && te_set && ctrl_q[IE_BIT];

  a_r9_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> rd_valid_o && $stable(rd_addr_o));
  a_r9_wr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && !wr_ready_i) |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));
  a_r9_rd_then_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_ready_i) |=> wr_valid_o);
  a_r4_illegal_no_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && dec_illegal) |=> wb_valid_o && !rd_valid_o);
  a_r7_irq_needs_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctrl_o[IE_BIT] && ctrl_o[TE_BIT] && count_o == '0);
  a_r10_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  a_r6_wb_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |=> !busy_o);
  a_r10_valid_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_valid_o, wr_valid_o, wb_valid_o}));
endmodule

// File: tb/dmaseq_top_tb_top.sv
module dmaseq_top_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [23:0]  run_units_i = '0;
  logic [31:0]  src_addr_i = '0, dst_addr_i = '0;
  logic [23:0]  count_i = '0;
  logic [15:0]  ctrl_i = '0;
  logic         busy_o, rd_valid_o, wr_valid_o, wb_valid_o, illegal_o, irq_o;
  logic         rd_ready_i = 1'b0, wr_ready_i = 1'b0;
  logic [31:0]  rd_addr_o, wr_addr_o, src_addr_o, dst_addr_o;
  logic [255:0] rd_data_i = '0, wr_data_o;
  logic [5:0]   unit_bytes_o;
  logic [23:0]  count_o;
  logic [15:0]  ctrl_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  dmaseq_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .run_units_i(run_units_i),
    .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i), .count_i(count_i), .ctrl_i(ctrl_i),
    .busy_o(busy_o), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data_i), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .unit_bytes_o(unit_bytes_o),
    .wb_valid_o(wb_valid_o), .src_addr_o(src_addr_o), .dst_addr_o(dst_addr_o),
    .count_o(count_o), .ctrl_o(ctrl_o), .illegal_o(illegal_o), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bsize(input logic [2:0] code);
    case (code)
      3'd0: return 8;
      3'd2: return 2;
      3'd3: return 4;
      3'd4: return 32;
      default: return 1;
    endcase
  endfunction

  function automatic logic [31:0] bstep(input logic [31:0] a, input logic [1:0] m, input int sz);
    case (m)
      2'd1: return a + sz;
      2'd2: return a - sz;
      default: return a;
    endcase
  endfunction

  function automatic logic [255:0] pat(input logic [31:0] a);
    return {8{a ^ 32'h5A3C_96E1}} ^ {a, 224'h0};
  endfunction

  function automatic logic [255:0] bmask(input int sz);
    if (sz >= 32) return '1;
    return (256'd1 << (8 * sz)) - 1;
  endfunction

  task automatic run_case(input logic [31:0] s, input logic [31:0] d, input logic [23:0] c,
                          input logic [15:0] ct, input logic [23:0] ru, input bit poke);
    int sz = bsize(ct[6:4]);
    logic [24:0] full = (c == 0) ? 25'h1000000 : {1'b0, c};
    logic [24:0] want = (ru == 0 || {1'b0, ru} > full) ? full : {1'b0, ru};
    bit bad = (ct[13:12] == 2'd3) || (ct[15:14] == 2'd3);
    logic [24:0] rem;
    logic [31:0] es = s, ed = d;
    logic [255:0] last_rd = '0;
    int units = 0;
    bit done = 0, poked = 0;
    logic [15:0] ectl;
    if (bad) want = 0;
    rem = full - want;
    @(negedge clk_i);
    src_addr_i = s; dst_addr_i = d; count_i = c; ctrl_i = ct; run_units_i = ru; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R10 busy after start", busy_o, 1);
    while (!done) begin
      start_i = 1'b0;
      if (wb_valid_o) begin
        done = 1;
        ectl = ct;
        if (!bad && rem == 0) ectl[1] = 1'b1;
        chk(units == int'(want), "R8 units moved", units, want);
        chk(src_addr_o === es, "R6 src writeback", src_addr_o, es);
        chk(dst_addr_o === ed, "R6 dst writeback", dst_addr_o, ed);
        chk(count_o === rem[23:0], "R5 R6 count writeback", count_o, rem[23:0]);
        chk(ctrl_o === ectl, "R7 ctrl writeback", ctrl_o, ectl);
        chk(irq_o === (!bad && rem == 0 && ct[2]), "R7 irq", irq_o, (!bad && rem == 0 && ct[2]));
        chk(illegal_o === bad, "R4 illegal flag", illegal_o, bad);
      end else begin
        rd_ready_i = rd_valid_o && ($urandom % 3 != 0);
        if (rd_ready_i) begin
          chk(!bad, "R4 no read on illegal", 1, 0);
          chk(rd_addr_o === es, "R2 read address", rd_addr_o, es);
          rd_data_i = pat(es);
          last_rd = pat(es);
        end
        wr_ready_i = wr_valid_o && ($urandom % 3 != 0);
        if (wr_ready_i) begin
          chk(wr_addr_o === ed, "R3 write address", wr_addr_o, ed);
          chk(unit_bytes_o == 6'(sz), "R1 unit size", unit_bytes_o, sz);
          chk((wr_data_o & bmask(sz)) === (last_rd & bmask(sz)), "R9 R1 write data",
              wr_data_o & bmask(sz), last_rd & bmask(sz));
          es = bstep(es, ct[13:12], sz);
          ed = bstep(ed, ct[15:14], sz);
          units++;
        end
        if (poke && !poked && rd_valid_o) begin
          poked = 1;
          start_i = 1'b1;
          src_addr_i = ~s; dst_addr_i = ~d; count_i = 24'h3; run_units_i = 24'h1; ctrl_i = ~ct;
        end
      end
      @(negedge clk_i);
    end
    start_i = 1'b0; rd_ready_i = 1'b0; wr_ready_i = 1'b0;
    chk(busy_o === 1'b0, "R10 idle after writeback", busy_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rs, rd;
    logic [23:0] rc;
    logic [15:0] rct;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    chk({busy_o, rd_valid_o, wr_valid_o, wb_valid_o, illegal_o, irq_o} === 6'b0, "R11 reset state",
        {busy_o, rd_valid_o, wr_valid_o, wb_valid_o, illegal_o, irq_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o === 1'b0, "R11 idle after reset", busy_o, 0);
    // R1: every size code, incrementing both sides
    for (int k = 0; k < 8; k++)
      run_case(32'h1000_0000, 32'h2000_0100, 24'd3, 16'h5000 | 16'(k << 4), 24'd0, 0);
    // R2 R3: decrement, fixed and mixed modes
    run_case(32'h0000_0010, 32'h3000_0000, 24'd4, 16'h9000 | 16'h0040, 24'd0, 0);
    run_case(32'h4000_0000, 32'h0000_0004, 24'd3, 16'h8030, 24'd0, 0);
    run_case(32'h0000_0008, 32'h5000_0000, 24'd2, 16'h2000, 24'd0, 0);
    // R4: illegal source, illegal destination
    run_case(32'h1111_0000, 32'h2222_0000, 24'd5, 16'h7014, 24'd0, 0);
    run_case(32'h1111_0000, 32'h2222_0000, 24'd0, 16'hC014, 24'd0, 0);
    // R5: zero count with limited run
    run_case(32'h6000_0000, 32'h7000_0000, 24'd0, 16'h5014, 24'd3, 0);
    // R8: limit above count, exact, zero
    run_case(32'h6000_0000, 32'h7000_0000, 24'd4, 16'h5024, 24'd9, 0);
    run_case(32'h6000_0000, 32'h7000_0000, 24'd4, 16'h5020, 24'd4, 0);
    // R7: end without interrupt enable, end with enable, partial with enable
    run_case(32'h0, 32'h100, 24'd1, 16'h5010, 24'd0, 0);
    run_case(32'h0, 32'h100, 24'd1, 16'h5014, 24'd0, 0);
    run_case(32'h0, 32'h100, 24'd6, 16'h5014, 24'd2, 0);
    // R6: resume from written-back values
    run_case(32'h8000_0000, 32'h9000_0000, 24'd5, 16'h5034, 24'd2, 0);
    rs = src_addr_o; rd = dst_addr_o; rc = count_o; rct = ctrl_o;
    chk(rc === 24'd3, "R6 resume count", rc, 3);
    run_case(rs, rd, rc, rct, 24'd0, 0);
    // R10: start raised mid-run is ignored
    run_case(32'hA000_0000, 32'hB000_0000, 24'd3, 16'h6024, 24'd0, 1);
    // random mix
    for (int n = 0; n < 30; n++) begin
      rct = 16'($urandom);
      rc  = 24'(1 + $urandom % 12);
      run_case($urandom, $urandom, rc, rct, 24'($urandom % 16), (n % 5) == 0);
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule